// File: doc/BRIEF.md
# Vertical Gate-Drive Sequencer for an Active-Matrix Panel

This block produces the row-side drive signals of an active-matrix display panel: a vertical start pulse, a vertical shift clock whose every edge steps the gate selection by one row, a gate-enable pulse, a precharge pulse and a black-frame blanking pulse. An upstream timing generator gives it one strobe at the start of each line and a master clock. All positions inside a line are counted in master clocks from that strobe.

A frame always lasts a fixed number of lines. A size input chooses between a tall picture of FULL_LINES rows and a short one of SHORT_LINES rows. The short window is shifted down by half the difference, so the picture stays centred. A direction input picks down or up scanning by choosing the idle level of the shift clock, and so which clock edge comes first. Both inputs are captured only when a new frame begins. The precharge output carries the OR of the precharge pulse and the blanking pulse, so a single pin carries both.

Top module: `vpanel_vseq`

## Requirements
- R1: A frame is TOTAL = FULL_LINES + BLANK_LINES strobes long. The strobe that follows line TOTAL-1 starts a new frame at line 0, and it alone samples `mode_full` and `scan_down`. Changes of these inputs at other times have no effect until then.
- R2: With `mode_full`=1 latched, `vck` toggles at the strobe that enters each of lines BLANK_LINES to BLANK_LINES+FULL_LINES-1, which is FULL_LINES toggles per frame, and at no other time.
- R3: With `mode_full`=0 latched, `vck` toggles SHORT_LINES times per frame. The first toggle is at line BLANK_LINES+(FULL_LINES-SHORT_LINES)/2, which keeps the short window centred in the tall one.
- R4: At frame start `vck` is set to its idle level: low for `scan_down`=1, so the first active edge rises; high for `scan_down`=0, so the first active edge falls.
- R5: `vst` is high from count VST_RISE of the line before the first active line up to, but not including, count VST_FALL of the first active line.
- R6: In an active line, `enb` is high for in-line counts ENB_RISE up to but not including ENB_FALL, where count 0 is the cycle of the strobe edge. It is low in all other lines.
- R7: In an active line, the precharge pulse is high from count ENB_FALL+PCG_GAP for PCG_WIDTH counts, after `enb` has fallen.
- R8: `blk` is high in lines 0 to BLK_LINES-1. Elaboration requires BLK_LINES+2 <= BLANK_LINES, so blanking ends at least one full line before `vst` rises.
- R9: `pcg_out` equals the precharge pulse ORed with `blk`.
- R10: Under reset and until the first strobe, all outputs are low. The in-line count saturates, so no pulse repeats when strobes stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_strobe | input | 1 | One-cycle pulse at the start of each line |
| mode_full | input | 1 | 1: tall window, 0: short centred window |
| scan_down | input | 1 | 1: down scan, 0: up scan |
| vst | output | 1 | Vertical start pulse |
| vck | output | 1 | Vertical shift clock, both edges active |
| enb | output | 1 | Gate-enable pulse |
| pcg_out | output | 1 | Precharge pulse ORed with blanking |
| blk | output | 1 | Black-frame blanking pulse |

## Verification
The bench builds the block with a 12-row tall window, an 8-row short window, 5 blanking lines of which 2 carry `blk`, and a 7-bit in-line counter. The sub-line offsets (enable at 3 to 30, precharge at 32 to 38, start pulse from 20 to 12) fit inside lines of about 50 clocks. With these values a whole frame takes under a thousand cycles. Both window sizes and both directions, including input changes in mid-frame, fit in many frames. Line lengths drawn between 26 and 70 clocks cut the enable pulse short in some lines. One frame of lines longer than 127 clocks drives the counter into saturation.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
   // Pulses decoded from the line position, before the output OR
   typedef struct packed {
      logic vst;
      logic enb;
      logic pre;
      logic blk;
   } vpulse_t;
endpackage

// File: rtl/vseq_line_tracker.sv
module vseq_line_tracker #(
   parameter int TOTAL_LINES = 624,
   parameter int LINE_W      = 10,
   parameter int CNT_W       = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_strobe,
   input  logic              mode_full,
   input  logic              scan_down,
   output logic [LINE_W-1:0] line_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              frame_start,
   output logic              mode_q,
   output logic              down_q
);
   localparam logic [LINE_W-1:0] LAST = LINE_W'(TOTAL_LINES - 1);

   assign frame_start = line_strobe && (line_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_q <= LAST;
         cnt_q  <= '1;
         mode_q <= 1'b1;
         down_q <= 1'b1;
      end else begin
         if (line_strobe) begin
            cnt_q  <= '0;
            line_q <= frame_start ? '0 : line_q + 1'b1;
         end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
         end
         if (frame_start) begin
            mode_q <= mode_full;
            down_q <= scan_down;
         end
      end
   end

   // R1: latched size and direction move only at a frame start
   a_r1_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> ($stable(mode_q) && $stable(down_q)));
   // R1: the line index never leaves the frame
   a_r1_line_range: assert property (@(posedge clk) disable iff (!rst_n)
      line_q <= LAST);
endmodule

// File: rtl/vseq_vclock.sv
module vseq_vclock (
   input  logic clk,
   input  logic rst_n,
   input  logic line_strobe,
   input  logic frame_start,
   input  logic scan_down,
   input  logic enter_active,
   output logic vck
);
   always_ff @(posedge clk) begin
      if (!rst_n)                          vck <= 1'b0;
      else if (frame_start)                vck <= ~scan_down;
      else if (line_strobe && enter_active) vck <= ~vck;
   end

   // R2: the shift clock only moves on a line strobe
   a_r2_vck_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !line_strobe |=> $stable(vck));
endmodule

// File: rtl/vseq_pulse_gen.sv
module vseq_pulse_gen
   import vseq_pkg::*;
#(
   parameter int FULL_LINES  = 604,
   parameter int SHORT_LINES = 500,
   parameter int BLANK_LINES = 20,
   parameter int BLK_LINES   = 4,
   parameter int LINE_W      = 10,
   parameter int CNT_W       = 13,
   parameter int ENB_RISE    = 140,
   parameter int ENB_FALL    = 3800,
   parameter int PCG_GAP     = 40,
   parameter int PCG_WIDTH   = 240,
   parameter int VST_RISE    = 2166,
   parameter int VST_FALL    = 2000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] line_q,
   input  logic [CNT_W-1:0]  cnt_q,
   input  logic              mode_q,
   input  logic              frame_start,
   output vpulse_t           pulses,
   output logic              enter_active
);
   localparam int MARGIN = (FULL_LINES - SHORT_LINES) / 2;
   localparam logic [LINE_W-1:0] FIRST_F = LINE_W'(BLANK_LINES);
   localparam logic [LINE_W-1:0] FIRST_S = LINE_W'(BLANK_LINES + MARGIN);
   localparam logic [LINE_W-1:0] LAST_F  = LINE_W'(BLANK_LINES + FULL_LINES - 1);
   localparam logic [LINE_W-1:0] LAST_S  = LINE_W'(BLANK_LINES + MARGIN + SHORT_LINES - 1);
   localparam logic [LINE_W-1:0] BLK_END = LINE_W'(BLK_LINES);
   localparam logic [CNT_W-1:0]  C_ER = CNT_W'(ENB_RISE);
   localparam logic [CNT_W-1:0]  C_EF = CNT_W'(ENB_FALL);
   localparam logic [CNT_W-1:0]  C_PS = CNT_W'(ENB_FALL + PCG_GAP);
   localparam logic [CNT_W-1:0]  C_PE = CNT_W'(ENB_FALL + PCG_GAP + PCG_WIDTH);
   localparam logic [CNT_W-1:0]  C_VR = CNT_W'(VST_RISE);
   localparam logic [CNT_W-1:0]  C_VF = CNT_W'(VST_FALL);

   function automatic logic in_window(input logic [LINE_W-1:0] l, input logic m);
      logic [LINE_W-1:0] lo, hi;
      lo = m ? FIRST_F : FIRST_S;
      hi = m ? LAST_F  : LAST_S;
      return (l >= lo) && (l <= hi);
   endfunction

   logic [LINE_W-1:0] first_l, next_l;
   logic              active;

   assign first_l      = mode_q ? FIRST_F : FIRST_S;
   assign next_l       = frame_start ? '0 : line_q + 1'b1;
   assign enter_active = in_window(next_l, mode_q);
   assign active       = in_window(line_q, mode_q);

   always_comb begin
      pulses.vst = ((line_q == first_l - 1'b1) && (cnt_q >= C_VR))
                || ((line_q == first_l) && (cnt_q < C_VF));
      pulses.enb = active && (cnt_q >= C_ER) && (cnt_q < C_EF);
      pulses.pre = active && (cnt_q >= C_PS) && (cnt_q < C_PE);
      pulses.blk = line_q < BLK_END;
   end

   // R8: blanking and the start pulse never overlap
   a_r8_blk_vst_apart: assert property (@(posedge clk) disable iff (!rst_n)
      pulses.blk |-> !pulses.vst);
   // R7: precharge only after enable has dropped
   a_r7_pre_after_enb: assert property (@(posedge clk) disable iff (!rst_n)
      pulses.pre |-> !pulses.enb);
   // R6: enable never during blanking lines
   a_r6_enb_not_blank: assert property (@(posedge clk) disable iff (!rst_n)
      pulses.enb |-> !pulses.blk);
   // R5: the start pulse rises only outside the active enable phase
   a_r5_vst_rise_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulses.vst) |-> !pulses.enb);
endmodule

// File: rtl/vpanel_vseq.sv
module vpanel_vseq
   import vseq_pkg::*;
#(
   parameter int FULL_LINES  = 604,
   parameter int SHORT_LINES = 500,
   parameter int BLANK_LINES = 20,
   parameter int BLK_LINES   = 4,
   parameter int CNT_W       = 13,
   parameter int ENB_RISE    = 140,
   parameter int ENB_FALL    = 3800,
   parameter int PCG_GAP     = 40,
   parameter int PCG_WIDTH   = 240,
   parameter int VST_RISE    = 2166,
   parameter int VST_FALL    = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_strobe,
   input  logic mode_full,
   input  logic scan_down,
   output logic vst,
   output logic vck,
   output logic enb,
   output logic pcg_out,
   output logic blk
);
   localparam int TOTAL_LINES = FULL_LINES + BLANK_LINES;
   localparam int LINE_W      = $clog2(TOTAL_LINES);
   localparam int CNT_SAT     = (1 << CNT_W) - 1;

   // Elaboration-time parameter checks
   if (SHORT_LINES > FULL_LINES || ((FULL_LINES - SHORT_LINES) % 2) != 0) begin : g_bad_size
      $error("short window must be smaller by an even number of lines");
   end
   if ((FULL_LINES % 2) != 0 || (SHORT_LINES % 2) != 0) begin : g_bad_parity
      $error("line counts must be even so the shift clock returns to idle");
   end
   if (BLK_LINES < 1 || BLK_LINES + 2 > BLANK_LINES) begin : g_bad_blank
      $error("blanking must end one line before the start pulse");
   end
   if (ENB_RISE >= ENB_FALL || ENB_FALL + PCG_GAP + PCG_WIDTH >= CNT_SAT ||
       VST_RISE >= CNT_SAT || VST_FALL >= CNT_SAT || PCG_WIDTH < 1) begin : g_bad_timing
      $error("sub-line offsets do not fit the in-line counter");
   end

   logic [LINE_W-1:0] line_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              frame_start, mode_q, down_q, enter_active;
   vpulse_t           pulses;

   vseq_line_tracker #(.TOTAL_LINES(TOTAL_LINES), .LINE_W(LINE_W), .CNT_W(CNT_W)) u_track (
      .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .mode_full(mode_full),
      .scan_down(scan_down), .line_q(line_q), .cnt_q(cnt_q), .frame_start(frame_start),
      .mode_q(mode_q), .down_q(down_q));

   vseq_pulse_gen #(
      .FULL_LINES(FULL_LINES), .SHORT_LINES(SHORT_LINES), .BLANK_LINES(BLANK_LINES),
      .BLK_LINES(BLK_LINES), .LINE_W(LINE_W), .CNT_W(CNT_W), .ENB_RISE(ENB_RISE),
      .ENB_FALL(ENB_FALL), .PCG_GAP(PCG_GAP), .PCG_WIDTH(PCG_WIDTH),
      .VST_RISE(VST_RISE), .VST_FALL(VST_FALL)) u_pulse (
      .clk(clk), .rst_n(rst_n), .line_q(line_q), .cnt_q(cnt_q), .mode_q(mode_q),
      .frame_start(frame_start), .pulses(pulses), .enter_active(enter_active));

   vseq_vclock u_vck (
      .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .frame_start(frame_start),
      .scan_down(scan_down), .enter_active(enter_active), .vck(vck));

   assign vst     = pulses.vst;
   assign enb     = pulses.enb;
   assign blk     = pulses.blk;
   assign pcg_out = pulses.pre | pulses.blk;

   // R4: the latched direction and the shift clock idle level agree between frames
   a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      (line_q == '0 && !line_strobe) |-> (vck == !down_q));
endmodule

// File: tb/test_vpanel_vseq.sv
`timescale 1ns/1ps
module test_vpanel_vseq;
   localparam int F_L = 12, S_L = 8, BL_L = 5, BK_L = 2, CW = 7;
   localparam int ER = 3, EF = 30, PG = 2, PW = 6, VR = 20, VF = 12;
   localparam int TOT = F_L + BL_L, SAT = (1 << CW) - 1, MG = (F_L - S_L) / 2;

   logic clk = 1'b0, rst_n = 1'b0, line_strobe = 1'b0, mode_full = 1'b1, scan_down = 1'b1;
   logic vst, vck, enb, pcg_out, blk;
   int   n_chk = 0, n_err = 0;
   bit   done = 1'b0;

   // model state, as it will be after the coming edge
   int m_line = TOT - 1, m_cnt = SAT;
   bit m_mode = 1'b1, m_down = 1'b1, m_vck = 1'b0;
   int edges, first_seen;
   logic prev_vck;

   always #2.5 clk = ~clk;

   vpanel_vseq #(.FULL_LINES(F_L), .SHORT_LINES(S_L), .BLANK_LINES(BL_L), .BLK_LINES(BK_L),
      .CNT_W(CW), .ENB_RISE(ER), .ENB_FALL(EF), .PCG_GAP(PG), .PCG_WIDTH(PW),
      .VST_RISE(VR), .VST_FALL(VF)) i_vpanel_vseq (
      .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .mode_full(mode_full),
      .scan_down(scan_down), .vst(vst), .vck(vck), .enb(enb), .pcg_out(pcg_out), .blk(blk));

   function automatic int first_of(bit m); return BL_L + (m ? 0 : MG); endfunction
   function automatic int rows_of(bit m);  return m ? F_L : S_L;       endfunction
   function automatic bit act(int l, bit m);
      return l >= first_of(m) && l < first_of(m) + rows_of(m);
   endfunction
   function automatic bit e_vst(int l, int c, bit m);
      return (l == first_of(m) - 1 && c >= VR) || (l == first_of(m) && c < VF);
   endfunction
   function automatic bit e_enb(int l, int c, bit m); return act(l, m) && c >= ER && c < EF; endfunction
   function automatic bit e_pre(int l, int c, bit m);
      return act(l, m) && c >= EF + PG && c < EF + PG + PW;
   endfunction
   function automatic bit e_blk(int l); return l < BK_L; endfunction

   task automatic chk(input bit ok, input string tag, input int actv, input int expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d line=%0d cnt=%0d", tag, actv, expv, m_line, m_cnt);
      end
   endtask

   task automatic compare();
      chk(vst === e_vst(m_line, m_cnt, m_mode), "R5 vst", int'(vst), int'(e_vst(m_line, m_cnt, m_mode)));
      chk(vck === m_vck, "R4 vck", int'(vck), int'(m_vck));
      chk(enb === e_enb(m_line, m_cnt, m_mode), "R6 enb", int'(enb), int'(e_enb(m_line, m_cnt, m_mode)));
      chk(blk === e_blk(m_line), "R8 blk", int'(blk), int'(e_blk(m_line)));
      chk(pcg_out === (e_pre(m_line, m_cnt, m_mode) | e_blk(m_line)), "R7 R9 pcg_out",
          int'(pcg_out), int'(e_pre(m_line, m_cnt, m_mode) | e_blk(m_line)));
   endtask

   // drive one cycle from a negedge and check at the next negedge
   task automatic cycle(input bit s);
      line_strobe = s;
      if (s) begin
         if (m_line == TOT - 1) begin
            m_line = 0; m_mode = mode_full; m_down = scan_down; m_vck = !scan_down;
         end else begin
            m_line++;
            if (act(m_line, m_mode)) m_vck = !m_vck;
         end
         m_cnt = 0;
      end else if (m_cnt < SAT) m_cnt++;
      @(negedge clk);
      compare();
      if (vck !== prev_vck && m_line != 0) begin
         edges++;
         if (first_seen < 0) first_seen = m_line;
      end
      prev_vck = vck;
   endtask

   task automatic run_frame(input bit m, input bit d, input int lo, input int hi, input int flip);
      mode_full = m; scan_down = d; edges = 0; first_seen = -1;
      for (int ln = 0; ln < TOT; ln++) begin
         int len;
         len = lo + int'($urandom % (hi - lo + 1));
         for (int i = 0; i < len; i++) begin
            cycle(i == 0);
            if (ln == 0 && i == 0) chk(vck === !d, "R4 idle level", int'(vck), int'(!d));
            if (ln == flip && i == 1) begin mode_full = !m; scan_down = !d; end
         end
      end
      if (m) begin
         chk(edges == F_L, "R2 edge count", edges, F_L);
         chk(first_seen == first_of(1'b1), "R2 first edge line", first_seen, first_of(1'b1));
      end else begin
         chk(edges == S_L, "R3 edge count", edges, S_L);
         chk(first_seen == first_of(1'b0), "R3 centred first line", first_seen, first_of(1'b0));
      end
      if (flip >= 0) chk(m_mode == m, "R1 mid-frame change ignored", int'(m_mode), int'(m));
   endtask

   initial begin
      void'($urandom(32'h5eed));
      repeat (3) @(negedge clk);
      chk({vst, vck, enb, pcg_out, blk} === 5'b0, "R10 reset state", int'({vst, vck, enb, pcg_out, blk}), 0);
      rst_n = 1'b1;
      prev_vck = vck;
      for (int i = 0; i < 150; i++) cycle(1'b0);   // R10: idle, counter saturates
      chk({vst, enb, pcg_out, blk} === 4'b0, "R10 idle quiet", int'({vst, enb, pcg_out, blk}), 0);
      run_frame(1'b1, 1'b1, 48, 48, -1);
      run_frame(1'b1, 1'b0, 48, 48, -1);
      run_frame(1'b0, 1'b1, 48, 48, 6);             // R1 flip during frame
      run_frame(1'b0, 1'b0, 48, 48, 3);
      for (int f = 0; f < 8; f++) begin
         bit fm, fd;
         int fl;
         fm = bit'($urandom % 2); fd = bit'($urandom % 2);
         fl = (($urandom % 3) == 0) ? -1 : int'($urandom % TOT);
         run_frame(fm, fd, 26, 70, fl);
      end
      run_frame(1'b0, 1'b1, 130, 140, -1);          // R10 saturation
      run_frame(1'b1, 1'b0, 26, 40, 10);
      if (!done) begin
         done = 1'b1;
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_err++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule